// File: doc/BRIEF.md
# Stack Pointer Unit

This block owns the stack pointer of a small processor core and carries out the stack operations that change it. The stack grows toward lower addresses, and the pointer always holds the address of the word that was pushed last. A push moves the pointer down by one word and writes a 32-bit value there. A pop reads the word at the pointer and then moves the pointer up by one word. An adjust command adds a signed offset to the pointer. The offset is a sign-extended 8-bit immediate, a sign-extended 16-bit immediate or a full register value.

Each new pointer value is masked as it is written. The two least significant bits are cleared, and so is every bit at or above the data-space span `ADDR_W`. The pointer therefore stays word aligned and wraps silently around the data space. The unit drives a word-wide request to an external data memory that has synchronous read. The word read by a pop comes back to the core one cycle after the request. Software can also load the pointer directly, and the same masking applies to that write.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer reads 0, no memory request is driven and `pop_valid_o` is low.
- R2: Bits 1:0 of `sp_o`, and every bit of `sp_o` at or above `ADDR_W`, are always zero.
- R3: A push (`cmd_i` = 3'd1) requests a write in the same cycle. The write goes to address (SP − 4) masked, with `mem_wdata_o` = `push_data_i`. From the next cycle the pointer equals that address.
- R4: A pop (`cmd_i` = 3'd2) requests a read at the current pointer in the same cycle. From the next cycle the pointer is (SP + 4) masked. In that next cycle `pop_valid_o` is high and `pop_data_o` carries the word the memory returned.
- R5: Adjust by 8-bit immediate (`cmd_i` = 3'd3) adds `imm_i[7:0]` sign-extended and ignores `imm_i[15:8]`. The sum is masked after the addition, so an unaligned offset yields a pointer with bits 1:0 cleared.
- R6: Adjust by 16-bit immediate (`cmd_i` = 3'd4) adds `imm_i[15:0]` sign-extended, then masks.
- R7: Adjust by register (`cmd_i` = 3'd5) adds `reg_val_i`, then masks.
- R8: Pointer arithmetic wraps modulo 2^`ADDR_W` on both underflow and overflow, and no fault is raised.
- R9: When `sp_wr_i` is high the pointer takes `sp_wr_data_i` masked on the next cycle. The command on `cmd_i` in that cycle is discarded, and no memory request is made.
- R10: Every memory request is a word access: `mem_size_o` = 2'b10, where the size code is 0 for a byte, 1 for a halfword and 2 for a word.
- R11: Idle (`cmd_i` = 3'd0) and the unused codes 3'd6 and 3'd7 leave the pointer unchanged and make no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Stack command code |
| imm_i | input | 16 | Immediate offset for the adjust commands |
| reg_val_i | input | 32 | Register offset for the adjust-by-register command |
| push_data_i | input | 32 | Word to be pushed |
| sp_wr_i | input | 1 | Direct pointer load strobe |
| sp_wr_data_i | input | 32 | Value for the direct pointer load |
| mem_req_o | output | 1 | Data memory request |
| mem_we_o | output | 1 | Write strobe, high for a push |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_size_o | output | 2 | Access size code |
| mem_wdata_o | output | 32 | Data to be written |
| mem_rdata_i | input | 32 | Data read from memory, valid one cycle after a read request |
| pop_valid_o | output | 1 | Popped word is valid |
| pop_data_o | output | 32 | Popped word |
| sp_o | output | 32 | Current stack pointer, zero-extended |

## Verification
Some rules hold on every cycle, and the in-RTL assertions check them directly. These are the pointer's alignment and span, the word size of every request, the absence of requests during direct loads and idle codes, and the one-cycle relations between a push or pop and the pointer that follows. Other behaviour depends on exact values, and only the directed scenarios can show it. The bench checks the numeric results of sign extension, the wrap at both ends of the data space, and the rounding of unaligned offsets. It also checks that the popped data is the same word an earlier push stored. It does this with a small memory model whose expected pointer is computed on its own.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  typedef enum logic [2:0] {
    SPC_IDLE  = 3'd0,
    SPC_PUSH  = 3'd1,
    SPC_POP   = 3'd2,
    SPC_ADD8  = 3'd3,
    SPC_ADD16 = 3'd4,
    SPC_ADDR  = 3'd5
  } sp_cmd_e;

  localparam logic [1:0] MSZ_BYTE = 2'd0;
  localparam logic [1:0] MSZ_HALF = 2'd1;
  localparam logic [1:0] MSZ_WORD = 2'd2;

  localparam logic [31:0] WORD_BYTES = 32'd4;

  // Keep bits [aw-1:2] and clear everything else.
  function automatic logic [31:0] sp_mask(input logic [31:0] v, input int unsigned aw);
    logic [32:0] span;
    span = (33'd1 << aw) - 33'd1;
    return v & span[31:0] & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] sext8(input logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

endpackage

// File: rtl/stkptr_next.sv
module stkptr_next
  import stkptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [31:0] sp_cur,
  input  logic [2:0]  cmd,
  input  logic [15:0] imm,
  input  logic [31:0] reg_val,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] sp_next,
  output logic        sp_load,
  output logic        push_evt,
  output logic        pop_evt
);

  logic [31:0] offset;
  logic        adj_evt;

  always_comb begin
    push_evt = 1'b0;
    pop_evt  = 1'b0;
    adj_evt  = 1'b0;
    offset   = 32'd0;
    if (!wr_en) begin
      case (cmd)
        SPC_PUSH:  begin push_evt = 1'b1; offset = 32'd0 - WORD_BYTES; end
        SPC_POP:   begin pop_evt  = 1'b1; offset = WORD_BYTES;         end
        SPC_ADD8:  begin adj_evt  = 1'b1; offset = sext8(imm[7:0]);    end
        SPC_ADD16: begin adj_evt  = 1'b1; offset = sext16(imm);        end
        SPC_ADDR:  begin adj_evt  = 1'b1; offset = reg_val;            end
        default:   offset = 32'd0;
      endcase
    end
  end

  always_comb begin
    if (wr_en) sp_next = sp_mask(wr_data, ADDR_W);
    else       sp_next = sp_mask(sp_cur + offset, ADDR_W);
  end

  assign sp_load = wr_en | push_evt | pop_evt | adj_evt;

endmodule

// File: rtl/stkptr_memif.sv
module stkptr_memif
  import stkptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_evt,
  input  logic              pop_evt,
  input  logic [ADDR_W-1:0] sp_cur_a,
  input  logic [ADDR_W-1:0] sp_dec_a,
  input  logic [31:0]       push_data,
  input  logic [31:0]       mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  output logic              pop_valid,
  output logic [31:0]       pop_data
);

  logic pop_pend_q;

  assign mem_req   = push_evt | pop_evt;
  assign mem_we    = push_evt;
  assign mem_addr  = push_evt ? sp_dec_a : (pop_evt ? sp_cur_a : '0);
  assign mem_size  = mem_req ? MSZ_WORD : MSZ_BYTE;
  assign mem_wdata = push_evt ? push_data : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) pop_pend_q <= 1'b0;
    else        pop_pend_q <= pop_evt;
  end

  assign pop_valid = pop_pend_q;
  assign pop_data  = pop_pend_q ? mem_rdata : 32'd0;

  // R4
  pop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> pop_valid);

  // R4
  pop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_evt |=> !pop_valid);

  // R10
  word_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size == MSZ_WORD);

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [15:0]       imm_i,
  input  logic [31:0]       reg_val_i,
  input  logic [31:0]       push_data_i,
  input  logic              sp_wr_i,
  input  logic [31:0]       sp_wr_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              pop_valid_o,
  output logic [31:0]       pop_data_o,
  output logic [31:0]       sp_o
);

  localparam logic [32:0] SPAN_M = (33'd1 << ADDR_W) - 33'd1;
  localparam logic [31:0] KEEP_M = SPAN_M[31:0] & 32'hFFFF_FFFC;

  logic [31:0] sp_q;
  logic [31:0] sp_next;
  logic        sp_load;
  logic        push_evt;
  logic        pop_evt;

  stkptr_next #(.ADDR_W(ADDR_W)) u_next (
    .sp_cur  (sp_q),
    .cmd     (cmd_i),
    .imm     (imm_i),
    .reg_val (reg_val_i),
    .wr_en   (sp_wr_i),
    .wr_data (sp_wr_data_i),
    .sp_next (sp_next),
    .sp_load (sp_load),
    .push_evt(push_evt),
    .pop_evt (pop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= 32'd0;
    else if (sp_load) sp_q <= sp_next;
  end

  stkptr_memif #(.ADDR_W(ADDR_W)) u_memif (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_evt (push_evt),
    .pop_evt  (pop_evt),
    .sp_cur_a (sp_q[ADDR_W-1:0]),
    .sp_dec_a (sp_next[ADDR_W-1:0]),
    .push_data(push_data_i),
    .mem_rdata(mem_rdata_i),
    .mem_req  (mem_req_o),
    .mem_we   (mem_we_o),
    .mem_addr (mem_addr_o),
    .mem_size (mem_size_o),
    .mem_wdata(mem_wdata_o),
    .pop_valid(pop_valid_o),
    .pop_data (pop_data_o)
  );

  assign sp_o = sp_q;

  // R2
  sp_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_o & ~KEEP_M) == 32'd0);

  // R3
  push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |=> sp_o[ADDR_W-1:0] == $past(mem_addr_o));

  // R4
  pop_reads_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> mem_addr_o == sp_o[ADDR_W-1:0]);

  // R9
  direct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_i |-> !mem_req_o);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_wr_i && (cmd_i == 3'd0 || cmd_i > 3'd5)) |=> $stable(sp_o));

endmodule

// File: tb/stkptr_unit_bench.sv
module stkptr_unit_bench;

  localparam int unsigned AW = 16;
  localparam logic [31:0] KEEP = 32'h0000_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_i = 3'd0;
  logic [15:0] imm_i = 16'd0;
  logic [31:0] reg_val_i = 32'd0;
  logic [31:0] push_data_i = 32'd0;
  logic        sp_wr_i = 1'b0;
  logic [31:0] sp_wr_data_i = 32'd0;
  logic        mem_req_o, mem_we_o, pop_valid_o;
  logic [AW-1:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [31:0] mem_wdata_o, pop_data_o, sp_o;
  logic [31:0] rdata_q = 32'd0;
  logic [31:0] mem [0:63];

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] exp_sp = 32'd0;

  always #10 clk = ~clk;

  stkptr_unit #(.ADDR_W(AW)) u_stkptr_unit (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .imm_i(imm_i),
    .reg_val_i(reg_val_i), .push_data_i(push_data_i), .sp_wr_i(sp_wr_i),
    .sp_wr_data_i(sp_wr_data_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(rdata_q), .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o),
    .sp_o(sp_o)
  );

  // Synchronous-read data memory model
  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o[7:2]] <= mem_wdata_o;
    if (mem_req_o && !mem_we_o) rdata_q <= mem[mem_addr_o[7:2]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_sp(input string req);
    chk(sp_o == exp_sp, req, sp_o, exp_sp);
    chk((sp_o & ~KEEP) == 32'd0, "R2", sp_o, sp_o & KEEP);
  endtask

  task automatic go_idle();
    cmd_i = 3'd0; sp_wr_i = 1'b0; imm_i = 16'd0; reg_val_i = 32'd0;
  endtask

  task automatic t_reset();
    chk(sp_o == 32'd0, "R1", sp_o, 32'd0);
    chk({31'd0, mem_req_o} == 32'd0, "R1", {31'd0, mem_req_o}, 32'd0);
    chk({31'd0, pop_valid_o} == 32'd0, "R1", {31'd0, pop_valid_o}, 32'd0);
  endtask

  task automatic t_push(input logic [31:0] val, input string req);
    @(negedge clk);
    cmd_i = 3'd1; push_data_i = val;
    exp_sp = (exp_sp - 32'd4) & KEEP;
    #1;
    chk(mem_req_o && mem_we_o, "R3", {30'd0, mem_req_o, mem_we_o}, 32'd3);
    chk({16'd0, mem_addr_o} == exp_sp, req, {16'd0, mem_addr_o}, exp_sp);
    chk(mem_wdata_o == val, "R3", mem_wdata_o, val);
    chk(mem_size_o == 2'd2, "R10", {30'd0, mem_size_o}, 32'd2);
    @(negedge clk); go_idle();
    chk_sp(req);
  endtask

  task automatic t_pop(input logic [31:0] expv, input string req);
    @(negedge clk);
    cmd_i = 3'd2;
    #1;
    chk(mem_req_o && !mem_we_o, "R4", {30'd0, mem_req_o, mem_we_o}, 32'd2);
    chk({16'd0, mem_addr_o} == exp_sp, "R4", {16'd0, mem_addr_o}, exp_sp);
    chk(mem_size_o == 2'd2, "R10", {30'd0, mem_size_o}, 32'd2);
    exp_sp = (exp_sp + 32'd4) & KEEP;
    @(negedge clk); go_idle();
    chk({31'd0, pop_valid_o} == 32'd1, "R4", {31'd0, pop_valid_o}, 32'd1);
    chk(pop_data_o == expv, "R4", pop_data_o, expv);
    chk_sp(req);
    @(negedge clk);
    chk({31'd0, pop_valid_o} == 32'd0, "R4", {31'd0, pop_valid_o}, 32'd0);
  endtask

  task automatic t_add(input logic [2:0] code, input logic [15:0] imm,
                       input logic [31:0] rv, input logic [31:0] new_sp, input string req);
    @(negedge clk);
    cmd_i = code; imm_i = imm; reg_val_i = rv;
    #1;
    chk({31'd0, mem_req_o} == 32'd0, req, {31'd0, mem_req_o}, 32'd0);
    exp_sp = new_sp;
    @(negedge clk); go_idle();
    chk_sp(req);
  endtask

  task automatic t_direct();
    @(negedge clk);
    sp_wr_i = 1'b1; sp_wr_data_i = 32'h1234_5677; cmd_i = 3'd1; push_data_i = 32'hDEAD_BEEF;
    #1;
    chk({31'd0, mem_req_o} == 32'd0, "R9", {31'd0, mem_req_o}, 32'd0);
    exp_sp = 32'h0000_5674;
    @(negedge clk); go_idle();
    chk_sp("R9");
  endtask

  task automatic t_idle_codes();
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c > 5) begin
        @(negedge clk);
        cmd_i = c[2:0]; imm_i = 16'h7FFF; reg_val_i = 32'h40;
        #1;
        chk({31'd0, mem_req_o} == 32'd0, "R11", {31'd0, mem_req_o}, 32'd0);
        @(negedge clk); go_idle();
        chk_sp("R11");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push(32'hA5A5_0001, "R8");   // 0 - 4 wraps to FFFC
    t_push(32'h5A5A_0002, "R3");   // FFF8
    t_pop(32'h5A5A_0002, "R4");    // back to FFFC
    t_pop(32'hA5A5_0001, "R8");    // FFFC + 4 wraps to 0
    t_add(3'd3, 16'h12F3, 32'd0, 32'h0000_FFF0, "R5");   // -13, high byte ignored, rounded
    t_add(3'd4, 16'h0105, 32'd0, 32'h0000_00F4, "R6");   // FFF0 + 0x105 wraps, masked
    t_add(3'd4, 16'hFF00, 32'd0, 32'h0000_FFF4, "R6");   // negative 16-bit offset
    t_add(3'd5, 16'd0, 32'hFFFF_FF00, 32'h0000_FEF4, "R7");
    t_add(3'd5, 16'd0, 32'h0000_0107, 32'h0000_FFF8, "R7");
    t_direct();
    t_idle_codes();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule